// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block holds the control state for an 8-bit general-purpose I/O port and reaches it through a simple synchronous register bus. The bus has an address, a write strobe, write data and read data. Each pin has a direction bit that enables its output driver, and an output latch bit that supplies the level it drives. A third register returns the pin levels as the port sees them. Pin levels pass through a synchronizer before a read can return them.

The direction register cannot be read. Its address also decodes a read-only view of a neighbouring 8-bit port, so a read at that address returns the neighbour's synchronized pin levels and never the direction bits. The output latch can be read and written at any time, whatever the direction setting. The read data is a combinational function of the address. Writes take effect on the clock edge that samples the strobe.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every direction bit and every output latch bit is 0. So `pad_oe` = 0x00, `pad_out` = 0x00, and a read at address 1 returns 0x00.
- R2: A write at address 0 loads `reg_wr_data` into the direction bits on the sampling edge, and `pad_oe` shows the new value from that edge on. Bit i = 1 enables the driver of pin i.
- R3: A write at address 1 loads the output latch, which drives `pad_out` from that edge on, whatever `pad_oe` holds. A read at address 1 returns the latched value.
- R4: A read at address 0 returns the neighbour port's pin levels (`nbr_pad_in`) as sampled two clock edges earlier. It never returns the direction bits.
- R5: A read at address 2 returns this port's `pad_in` as sampled two clock edges earlier. The synchronizer is two flops deep.
- R6: Address 3 is unmapped. A read there returns 0x00, and a write there changes neither the direction bits nor the output latch.
- R7: A write at address 2, which is read-only, has no effect on the direction bits or the output latch.
- R8: A pin that is set as an output reads back its own driven level through address 2.
- R9: When `reg_wr_en` is low, neither register changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data for the current address |
| pad_out | output | 8 | Level each pin drives when enabled |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_in | input | 8 | This port's pin levels |
| nbr_pad_in | input | 8 | Neighbouring port's pin levels |

## Verification
On every cycle, the assertions check that the direction and latch registers load only on a valid write and otherwise hold. They also check the two-edge lag of both pin views, and that the unmapped address reads zero. Other behaviour can be shown only by the bench's scenarios, because it depends on how the pads are wired. One case is that a driven pin reads back its own level. Another is that the direction bits never leak onto the read bus. A third is that long random mixes of writes to read-only and unmapped addresses leave the state intact.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned DEF_WIDTH       = 8;
   localparam int unsigned DEF_ADDR_W      = 2;
   localparam int unsigned DEF_SYNC_STAGES = 2;
   // Default address map
   localparam int unsigned DEF_ADDR_DIR    = 0;   // write: direction, read: neighbour pins
   localparam int unsigned DEF_ADDR_OUT    = 1;   // output latch, read/write
   localparam int unsigned DEF_ADDR_PIN    = 2;   // own pins, read-only

   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_NBR  = 2'd1,
      RSEL_OUT  = 2'd2,
      RSEL_PIN  = 2'd3
   } rd_sel_e;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
   parameter int unsigned WIDTH    = 8,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned ADDR_DIR = 0,
   parameter int unsigned ADDR_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  out_q
);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(ADDR_DIR);
   localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(ADDR_OUT);

   logic hit_dir, hit_out;
   assign hit_dir = wr_en && (wr_addr == A_DIR);
   assign hit_out = wr_en && (wr_addr == A_OUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
      end else begin
         if (hit_dir) dir_q <= wr_data;
         if (hit_out) out_q <= wr_data;
      end
   end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned ADDR_DIR = 0,
   parameter int unsigned ADDR_OUT = 1,
   parameter int unsigned ADDR_PIN = 2
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [WIDTH-1:0]  nbr_sync,
   input  logic [WIDTH-1:0]  out_q,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  rd_data
);
   rd_sel_e sel;

   always_comb begin
      if (rd_addr == ADDR_W'(ADDR_DIR))      sel = RSEL_NBR;
      else if (rd_addr == ADDR_W'(ADDR_OUT)) sel = RSEL_OUT;
      else if (rd_addr == ADDR_W'(ADDR_PIN)) sel = RSEL_PIN;
      else                                   sel = RSEL_NONE;
   end

   always_comb begin
      unique case (sel)
         RSEL_NBR: rd_data = nbr_sync;
         RSEL_OUT: rd_data = out_q;
         RSEL_PIN: rd_data = pin_sync;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH       = DEF_WIDTH,
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int unsigned ADDR_DIR    = DEF_ADDR_DIR,
   parameter int unsigned ADDR_OUT    = DEF_ADDR_OUT,
   parameter int unsigned ADDR_PIN    = DEF_ADDR_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [WIDTH-1:0]  reg_wr_data,
   output logic [WIDTH-1:0]  reg_rd_data,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   input  logic [WIDTH-1:0]  pad_in,
   input  logic [WIDTH-1:0]  nbr_pad_in
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (WIDTH < 1)
      $error("gpio_port_regs: WIDTH must be at least 1");
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4)
      $error("gpio_port_regs: SYNC_STAGES must be 2..4");
   if (ADDR_DIR >= ADDR_SPAN || ADDR_OUT >= ADDR_SPAN || ADDR_PIN >= ADDR_SPAN)
      $error("gpio_port_regs: register address outside ADDR_W range");
   if (ADDR_DIR == ADDR_OUT || ADDR_DIR == ADDR_PIN || ADDR_OUT == ADDR_PIN)
      $error("gpio_port_regs: register addresses must be distinct");

   logic [WIDTH-1:0] dir_q, out_q, pin_sync, nbr_sync;

   gpio_ctrl_regs #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W), .ADDR_DIR(ADDR_DIR), .ADDR_OUT(ADDR_OUT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_addr(reg_addr), .wr_en(reg_wr_en),
      .wr_data(reg_wr_data), .dir_q(dir_q), .out_q(out_q)
   );

   gpio_sync_chain #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync_own (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
   );

   gpio_sync_chain #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync_nbr (
      .clk(clk), .rst_n(rst_n), .async_in(nbr_pad_in), .sync_out(nbr_sync)
   );

   gpio_rd_mux #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W), .ADDR_DIR(ADDR_DIR),
      .ADDR_OUT(ADDR_OUT), .ADDR_PIN(ADDR_PIN)
   ) u_rd (
      .rd_addr(reg_addr), .nbr_sync(nbr_sync), .out_q(out_q),
      .pin_sync(pin_sync), .rd_data(reg_rd_data)
   );

   assign pad_oe  = dir_q;
   assign pad_out = out_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_DIR    = 0,
   parameter int unsigned ADDR_OUT    = 1,
   parameter int unsigned ADDR_PIN    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr_en,
   input logic [WIDTH-1:0]  reg_wr_data,
   input logic [WIDTH-1:0]  reg_rd_data,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  pad_oe,
   input logic [WIDTH-1:0]  pad_in,
   input logic [WIDTH-1:0]  nbr_pad_in
);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(ADDR_DIR);
   localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(ADDR_OUT);
   localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(ADDR_PIN);

   // Cycles since reset release, saturating, so lag checks start only once history exists
   logic [2:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= '0;
      else if (age_q != 3'd7) age_q <= age_q + 3'd1;
   end

   logic unmapped;
   assign unmapped = (reg_addr != A_DIR) && (reg_addr != A_OUT) && (reg_addr != A_PIN);

   // R1: reset holds drivers off and latch low
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0 && pad_out == '0));

   // R2: direction write lands on the next edge
   a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == A_DIR) |=> pad_oe == $past(reg_wr_data));

   // R3: latch write lands on the next edge
   a_r3_out_load: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == A_OUT) |=> pad_out == $past(reg_wr_data));

   // R9, R6, R7: no matching write keeps direction unchanged
   a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_addr == A_DIR) |=> $stable(pad_oe));

   // R9, R6, R7: no matching write keeps latch unchanged
   a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_addr == A_OUT) |=> $stable(pad_out));

   // R4: neighbour pins seen with synchronizer lag
   a_r4_nbr_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 3'(SYNC_STAGES) && reg_addr == A_DIR) |-> reg_rd_data == $past(nbr_pad_in, SYNC_STAGES));

   // R5: own pins seen with synchronizer lag
   a_r5_pin_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 3'(SYNC_STAGES) && reg_addr == A_PIN) |-> reg_rd_data == $past(pad_in, SYNC_STAGES));

   // R3: latch read matches drive
   a_r3_out_read: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_OUT) |-> reg_rd_data == pad_out);

   // R6: unmapped address reads zero
   a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> reg_rd_data == '0);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
   .ADDR_DIR(ADDR_DIR), .ADDR_OUT(ADDR_OUT), .ADDR_PIN(ADDR_PIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
   .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .pad_out(pad_out),
   .pad_oe(pad_oe), .pad_in(pad_in), .nbr_pad_in(nbr_pad_in)
);

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wr_data = '0;
   logic [7:0] reg_rd_data, pad_out, pad_oe, pad_in;
   logic [7:0] nbr_pad_in = '0;
   logic [7:0] ext_pins = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Model state
   logic [7:0] dir_m = '0, out_m = '0;
   logic [7:0] pin_h1, pin_h2, nbr_h1, nbr_h2;

   always #2 clk = ~clk;   // 250 MHz

   // Pad model: a driven pin reflects its own output
   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_pins);

   gpio_port_regs u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_in(pad_in), .nbr_pad_in(nbr_pad_in)
   );

   // Two-edge lag history of pin levels (requirement R4, R5)
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_h1 <= '0; pin_h2 <= '0; nbr_h1 <= '0; nbr_h2 <= '0;
      end else begin
         pin_h1 <= pad_in;     pin_h2 <= pin_h1;
         nbr_h1 <= nbr_pad_in; nbr_h2 <= nbr_h1;
      end
   end

   function automatic logic [7:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return nbr_h2;
         2'd1:    return out_m;
         2'd2:    return pin_h2;
         default: return 8'h00;
      endcase
   endfunction

   function automatic string read_tag(input logic [1:0] a);
      case (a)
         2'd0:    return "R4";
         2'd1:    return "R3";
         2'd2:    return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // One bus cycle: drive at negedge, check, clock, update model
   task automatic step(input logic [1:0] a, input logic we, input logic [7:0] wd,
                       input logic [7:0] ext, input logic [7:0] nbr, input string tag);
      reg_addr = a; reg_wr_en = we; reg_wr_data = wd;
      ext_pins = ext; nbr_pad_in = nbr;
      #0.5;
      check((tag != "") ? tag : read_tag(a), reg_rd_data, exp_read(a));
      check("R2", pad_oe, dir_m);
      check("R3", pad_out, out_m);
      @(posedge clk);
      if (we && a == 2'd0) dir_m = wd;
      if (we && a == 2'd1) out_m = wd;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] keep_dir, keep_out;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", pad_oe, 8'h00);
      check("R1", pad_out, 8'h00);
      reg_addr = 2'd1; #0.5;
      check("R1", reg_rd_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: direction write; the read at address 0 must not return it (R4)
      step(2'd0, 1'b1, 8'hA5, 8'h00, 8'h3C, "R4");
      step(2'd0, 1'b0, 8'h00, 8'h00, 8'h3C, "R4");
      check("R2", pad_oe, 8'hA5);
      step(2'd0, 1'b0, 8'hFF, 8'h00, 8'h3C, "R4");
      check("R4", reg_rd_data, 8'h3C);

      // R3: latch read/write while pins are inputs and outputs
      step(2'd1, 1'b1, 8'h5A, 8'h00, 8'h00, "R3");
      step(2'd1, 1'b0, 8'h00, 8'h00, 8'h00, "R3");
      check("R3", reg_rd_data, 8'h5A);

      // R7: write to read-only pin address has no effect
      step(2'd2, 1'b1, 8'hFF, 8'h00, 8'h00, "R5");
      check("R7", pad_oe, 8'hA5);
      check("R7", pad_out, 8'h5A);

      // R6: unmapped write ignored, read zero
      step(2'd3, 1'b1, 8'hFF, 8'h00, 8'h00, "R6");
      check("R6", pad_oe, 8'hA5);
      check("R6", pad_out, 8'h5A);
      reg_addr = 2'd3; #0.5;
      check("R6", reg_rd_data, 8'h00);

      // R9: address hits without strobe change nothing
      step(2'd0, 1'b0, 8'h0F, 8'h00, 8'h00, "R9");
      step(2'd1, 1'b0, 8'hF0, 8'h00, 8'h00, "R9");
      check("R9", pad_oe, 8'hA5);
      check("R9", pad_out, 8'h5A);

      // R5: two-edge lag of own pins, all inputs
      step(2'd0, 1'b1, 8'h00, 8'h00, 8'h00, "R4");
      step(2'd2, 1'b0, 8'h00, 8'h00, 8'h00, "R5");
      step(2'd2, 1'b0, 8'h00, 8'hC3, 8'h00, "R5");
      check("R5", reg_rd_data, 8'h00);   // one edge after change
      step(2'd2, 1'b0, 8'h00, 8'hC3, 8'h00, "R5");
      check("R5", reg_rd_data, 8'hC3);   // two edges after change

      // R8: driven pins read their own level, not the external one
      step(2'd1, 1'b1, 8'h3C, 8'hFF, 8'h00, "R3");
      step(2'd0, 1'b1, 8'hFF, 8'hFF, 8'h00, "R4");
      step(2'd2, 1'b0, 8'h00, 8'hFF, 8'h00, "R8");
      step(2'd2, 1'b0, 8'h00, 8'hFF, 8'h00, "R8");
      check("R8", reg_rd_data, 8'h3C);

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] a;
         a = 2'($urandom_range(0, 3));
         keep_dir = dir_m; keep_out = out_m;
         step(a, 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom), 8'($urandom), "");
         if (a >= 2'd2) begin
            check("R7", pad_oe, keep_dir);
            check("R6", pad_out, keep_out);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule